// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a calendar clock that occupies eight byte locations on a synchronous register bus, normally the top eight addresses of a byte-wide memory map. Inside, a chain of BCD counters holds seconds, minutes, hours in 24-hour form, weekday, date, month and two-digit year. The chain moves forward by one second on each pulse of a 1 Hz tick input. Software never reads the counters directly. It reads a second, user-visible bank of the same fields, and that bank is copied from the counters on every tick, with all fields copied in the same cycle.

The control byte carries two freeze bits that gate the copy in each direction. The read-freeze bit holds the visible bank still so that a multi-byte read is coherent, while the counters keep running. The write-freeze bit also holds the bank, and it opens the time offsets to writes. When that bit is cleared, the whole bank is moved into the counters as one load. An oscillator-stop bit in the seconds byte halts the counters. It comes out of reset set.

Top module: `rtc_regbank`

## Requirements
- R1: After reset the offsets read as follows: control (offset 0) reads 0x00, seconds (offset 1) reads 0x80, minutes (2) 0x00, hours (3) 0x00, weekday (4) 0x01, date (5) 0x01, month (6) 0x01 and year (7) 0x00. Reads take cs=1 and we=0 and are combinational from addr.
- R2: On each tick with the stop bit clear, the counters advance one second in BCD. Seconds and minutes wrap 59 to 00, hours wrap 23 to 00, the weekday wraps 7 to 1, the month wraps 12 to 01 and the year wraps 99 to 00, each carrying into the next field.
- R3: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. In February it wraps after 29 when the BCD year is a multiple of 4 and after 28 otherwise.
- R4: On a tick while control bits 7 and 6 are both 0, every visible time field takes the newly advanced counter value at that same clock edge.
- R5: While control bit 6 (read freeze) is 1, the visible fields do not change, but the counters keep advancing. Once the bit is cleared, the next tick shows the current time.
- R6: A control write that sets a freeze bit in the same cycle as a tick does not block that tick's refresh. The frozen values include it.
- R7: Writes to offsets 1 to 7 are stored only while control bit 7 (write freeze) is 1. Otherwise they are ignored.
- R8: A control write that takes bit 7 from 1 to 0 loads all visible fields into the counters. Later ticks count on from the written time.
- R9: Seconds bit 7 is the stop bit. It resets to 1, it can be written only under write freeze, and while it is 1 the counters do not advance.
- R10: Control bits 5 to 0 read back as written and have no effect on timekeeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| cs | input | 1 | Register select |
| we | input | 1 | Write strobe, qualified by cs |
| addr | input | 3 | Register offset, 0 is control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |

## Verification
The bench aims at the full rollover from 23:59:59 on 31 December of year 99, and at the three February cases: a leap year, a common year, and the 29th of a leap year. A design with a wrong carry or a wrong month-length table would show a date such as 02/30, or a date of 01 in the wrong month. It sets a freeze bit in the same cycle as a tick; a design that gave the new bit priority would lose that second. It holds a read freeze across several ticks and then releases it; a design that stopped the counters during the freeze would come back behind by those seconds. Time writes made without write freeze, changes to the calibration-like low control bits, and the reset state of the stop bit are all checked at the read port. Seeded random traffic mixes all of these against a bench model that keeps its time in binary.

// File: rtl/rtc_regbank_pkg.sv
`timescale 1ns/1ps
package rtc_regbank_pkg;

   typedef struct packed {
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hr;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam rtc_time_t TIME_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                        dow: 8'h01, hr: 8'h00, min: 8'h00,
                                        sec: 8'h00};

   // next BCD value of a field that wraps from top back to bottom
   function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] top,
                                           input logic [7:0] bottom, input logic en);
      logic [7:0] r;
      if (!en)
         r = v;
      else if (v >= top)
         r = bottom;
      else if (v[3:0] >= 4'h9)
         r = {v[7:4] + 4'h1, 4'h0};
      else
         r = {v[7:4], v[3:0] + 4'h1};
      return r;
   endfunction

   function automatic logic bcd_wraps(input logic [7:0] v, input logic [7:0] top, input logic en);
      return en && (v >= top);
   endfunction

   // a two-digit BCD year is a multiple of four
   function automatic logic is_leap(input logic [7:0] yr);
      logic r;
      if (yr[4])
         r = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
      else
         r = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
      return r;
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
      logic [7:0] r;
      case (mon)
         8'h02:                      r = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

   function automatic logic [7:0] get_field(input rtc_time_t t, input logic [2:0] idx);
      logic [7:0] r;
      case (idx)
         3'd1:    r = t.sec;
         3'd2:    r = t.min;
         3'd3:    r = t.hr;
         3'd4:    r = t.dow;
         3'd5:    r = t.date;
         3'd6:    r = t.mon;
         3'd7:    r = t.yr;
         default: r = 8'h00;
      endcase
      return r;
   endfunction

   function automatic rtc_time_t set_field(input rtc_time_t t, input logic [2:0] idx,
                                           input logic [7:0] v);
      rtc_time_t r;
      r = t;
      case (idx)
         3'd1:    r.sec  = v;
         3'd2:    r.min  = v;
         3'd3:    r.hr   = v;
         3'd4:    r.dow  = v;
         3'd5:    r.date = v;
         3'd6:    r.mon  = v;
         3'd7:    r.yr   = v;
         default: r = t;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_time_core.sv
`timescale 1ns/1ps
module rtc_time_core
   import rtc_regbank_pkg::*;
#(
   parameter bit LEAP_EN   = 1'b1,
   parameter int WDAY_LAST = 7
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t cnt,
   output rtc_time_t cnt_nxt
);

   localparam logic [7:0] WDAY_TOP = 8'(WDAY_LAST);

   generate
      if (WDAY_LAST < 2 || WDAY_LAST > 9) begin : g_bad_wday
         $error("rtc_time_core: WDAY_LAST must be 2..9");
      end
   endgenerate

   logic [7:0] dim;
   generate
      if (LEAP_EN) begin : g_leap
         assign dim = month_len(cnt.mon, is_leap(cnt.yr));
      end else begin : g_noleap
         assign dim = month_len(cnt.mon, 1'b0);
      end
   endgenerate

   logic c_sec, c_min, c_hr, c_date, c_mon;

   always_comb begin
      c_sec  = bcd_wraps(cnt.sec, 8'h59, adv);
      c_min  = bcd_wraps(cnt.min, 8'h59, c_sec);
      c_hr   = bcd_wraps(cnt.hr, 8'h23, c_min);
      c_date = bcd_wraps(cnt.date, dim, c_hr);
      c_mon  = bcd_wraps(cnt.mon, 8'h12, c_date);
      cnt_nxt.sec  = bcd_next(cnt.sec, 8'h59, 8'h00, adv);
      cnt_nxt.min  = bcd_next(cnt.min, 8'h59, 8'h00, c_sec);
      cnt_nxt.hr   = bcd_next(cnt.hr, 8'h23, 8'h00, c_min);
      cnt_nxt.dow  = bcd_next(cnt.dow, WDAY_TOP, 8'h01, c_hr);
      cnt_nxt.date = bcd_next(cnt.date, dim, 8'h01, c_hr);
      cnt_nxt.mon  = bcd_next(cnt.mon, 8'h12, 8'h01, c_date);
      cnt_nxt.yr   = bcd_next(cnt.yr, 8'h99, 8'h00, c_mon);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= TIME_RESET;
      else if (load)
         cnt <= load_val;
      else
         cnt <= cnt_nxt;
   end

   // R2
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && cnt.sec == 8'h59) |=> (cnt.sec == 8'h00));

   // R2
   hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && cnt.sec == 8'h59 && cnt.min == 8'h59 && cnt.hr == 8'h23)
      |=> (cnt.hr == 8'h00 && cnt.min == 8'h00));

   // R3
   date_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_hr && !load && cnt.date == dim) |=> (cnt.date == 8'h01));

endmodule

// File: rtl/rtc_user_bank.sv
`timescale 1ns/1ps
module rtc_user_bank
   import rtc_regbank_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       refresh,
   input  rtc_time_t  fresh,
   input  logic       wr_en,
   input  logic [2:0] wr_idx,
   input  logic [7:0] wr_data,
   output rtc_time_t  usr
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         usr <= TIME_RESET;
      else if (refresh)
         usr <= fresh;
      else if (wr_en)
         usr <= set_field(usr, wr_idx, wr_data);
   end

   // R4
   bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!refresh && !wr_en) |=> $stable(usr));

endmodule

// File: rtl/rtc_regbank.sv
`timescale 1ns/1ps
module rtc_regbank
   import rtc_regbank_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8,
   parameter bit LEAP_EN   = 1'b1,
   parameter int WDAY_LAST = 7,
   parameter bit READ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int NREG   = 1 << ADDR_W;
   localparam int WR_BIT = DATA_W - 1;
   localparam int RD_BIT = DATA_W - 2;

   generate
      if (NREG != 8) begin : g_bad_addr
         $error("rtc_regbank: the map needs exactly eight offsets");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("rtc_regbank: BCD fields are byte wide");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q;
   logic              stop_q;
   rtc_time_t         cnt_q, cnt_nxt, usr_q;

   logic bus_wr, ctrl_wr, time_wr, frz, refresh, load, adv;
   logic [DATA_W-1:0] time_data;

   always_comb begin
      bus_wr    = cs && we;
      ctrl_wr   = bus_wr && (addr == '0);
      time_wr   = bus_wr && (addr != '0) && ctrl_q[WR_BIT];
      frz       = ctrl_q[WR_BIT] || ctrl_q[RD_BIT];
      refresh   = tick_1hz && !frz;
      load      = ctrl_wr && ctrl_q[WR_BIT] && !wdata[WR_BIT];
      adv       = tick_1hz && !stop_q;
      time_data = (addr == 3'd1) ? {1'b0, wdata[DATA_W-2:0]} : wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         stop_q <= 1'b1;
      end else begin
         if (ctrl_wr)
            ctrl_q <= wdata;
         if (time_wr && addr == 3'd1)
            stop_q <= wdata[WR_BIT];
      end
   end

   rtc_time_core #(.LEAP_EN(LEAP_EN), .WDAY_LAST(WDAY_LAST)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .load     (load),
      .load_val (usr_q),
      .cnt      (cnt_q),
      .cnt_nxt  (cnt_nxt)
   );

   rtc_user_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .refresh (refresh),
      .fresh   (cnt_nxt),
      .wr_en   (time_wr),
      .wr_idx  (addr),
      .wr_data (time_data),
      .usr     (usr_q)
   );

   logic [DATA_W-1:0] rd_val;
   always_comb begin
      if (!cs || we)
         rd_val = '0;
      else if (addr == '0)
         rd_val = ctrl_q;
      else if (addr == 3'd1)
         rd_val = {stop_q, usr_q.sec[DATA_W-2:0]};
      else
         rd_val = get_field(usr_q, addr);
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               rdata <= '0;
            else
               rdata <= rd_val;
         end
      end else begin : g_rd_comb
         assign rdata = rd_val;
      end
   endgenerate

   // R4 R6
   refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !frz) |=> (usr_q == cnt_q));

   // R5
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && !time_wr) |=> $stable(usr_q));

   // R7
   write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && addr != '0 && !ctrl_q[WR_BIT] && !tick_1hz) |=> $stable(usr_q));

   // R8
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(usr_q)));

   // R9
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !load) |=> $stable(cnt_q));

endmodule

// File: tb/tb_rtc_regbank.sv
`timescale 1ns/1ps
module tb_rtc_regbank;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       cs = 1'b0;
   logic       we = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rtc_regbank dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .cs(cs), .we(we),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   // reference state: binary-arithmetic model of the requirements
   logic [7:0] mc [1:7];
   logic [7:0] mu [1:7];
   logic [7:0] nc [1:7];
   logic [7:0] nu [1:7];
   logic [7:0] mctrl;
   logic       mstop;

   function automatic int b2i(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int i);
      return {4'(i / 10), 4'(i % 10)};
   endfunction

   function automatic int mlen(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 1; i <= 7; i++) mc[i] = 8'h00;
         mc[4] = 8'h01; mc[5] = 8'h01; mc[6] = 8'h01;
         for (int i = 1; i <= 7; i++) mu[i] = mc[i];
         mctrl = 8'h00;
         mstop = 1'b1;
      end else begin
         for (int i = 1; i <= 7; i++) begin nc[i] = mc[i]; nu[i] = mu[i]; end
         if (tick_1hz && !mstop) begin
            if (b2i(nc[1]) < 59) nc[1] = i2b(b2i(nc[1]) + 1);
            else begin
               nc[1] = 8'h00;
               if (b2i(nc[2]) < 59) nc[2] = i2b(b2i(nc[2]) + 1);
               else begin
                  nc[2] = 8'h00;
                  if (b2i(nc[3]) < 23) nc[3] = i2b(b2i(nc[3]) + 1);
                  else begin
                     nc[3] = 8'h00;
                     nc[4] = (nc[4] >= 8'h07) ? 8'h01 : nc[4] + 8'h01;
                     if (b2i(nc[5]) < mlen(b2i(nc[6]), b2i(nc[7]))) nc[5] = i2b(b2i(nc[5]) + 1);
                     else begin
                        nc[5] = 8'h01;
                        if (b2i(nc[6]) < 12) nc[6] = i2b(b2i(nc[6]) + 1);
                        else begin
                           nc[6] = 8'h01;
                           nc[7] = i2b((b2i(nc[7]) + 1) % 100);
                        end
                     end
                  end
               end
            end
         end
         if (tick_1hz && !mctrl[7] && !mctrl[6])
            for (int i = 1; i <= 7; i++) nu[i] = nc[i];
         if (cs && we && addr == 3'd0 && mctrl[7] && !wdata[7])
            for (int i = 1; i <= 7; i++) nc[i] = mu[i];
         if (cs && we && addr != 3'd0 && mctrl[7]) begin
            if (addr == 3'd1) begin nu[1] = {1'b0, wdata[6:0]}; mstop = wdata[7]; end
            else nu[addr] = wdata;
         end
         if (cs && we && addr == 3'd0) mctrl = wdata;
         for (int i = 1; i <= 7; i++) begin mc[i] = nc[i]; mu[i] = nu[i]; end
      end
   end

   function automatic logic [7:0] expv(input int a);
      if (a == 0) return mctrl;
      if (a == 1) return {mstop, mu[1][6:0]};
      return mu[a];
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic cyc(input bit c, input bit w, input logic [2:0] a,
                      input logic [7:0] d, input bit t);
      @(negedge clk);
      cs = c; we = w; addr = a; wdata = d; tick_1hz = t;
   endtask

   task automatic idle(input int n, input bit t);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 8'h00, t);
   endtask

   task automatic peek(input string tag, input logic [2:0] a, input logic [7:0] exp);
      @(negedge clk);
      cs = 1'b1; we = 1'b0; tick_1hz = 1'b0; addr = a;
      #0.5;
      chk(tag, rdata, exp);
   endtask

   task automatic check_all(input string tag);
      @(negedge clk);
      cs = 1'b1; we = 1'b0; tick_1hz = 1'b0;
      for (int a = 0; a < 8; a++) begin
         addr = 3'(a);
         #0.4;
         chk(tag, rdata, expv(a));
      end
   endtask

   task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] wd, input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] y);
      cyc(1, 1, 3'd0, 8'h80, 0);
      cyc(1, 1, 3'd1, s, 0);
      cyc(1, 1, 3'd2, mi, 0);
      cyc(1, 1, 3'd3, h, 0);
      cyc(1, 1, 3'd4, wd, 0);
      cyc(1, 1, 3'd5, dt, 0);
      cyc(1, 1, 3'd6, mo, 0);
      cyc(1, 1, 3'd7, y, 0);
      cyc(1, 1, 3'd0, 8'h00, 0);
      idle(1, 0);
   endtask

   function automatic logic [7:0] rnd_field(input int a);
      case (a)
         1: return {($urandom_range(7) == 0) ? 1'b1 : 1'b0, 7'(i2b(int'($urandom_range(59))))};
         2: return i2b(int'($urandom_range(59)));
         3: return i2b(int'($urandom_range(23)));
         4: return i2b(int'($urandom_range(7, 1)));
         5: return i2b(int'($urandom_range(28, 1)));
         6: return i2b(int'($urandom_range(12, 1)));
         default: return i2b(int'($urandom_range(99)));
      endcase
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      idle(3, 0);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset image
      check_all("R1");
      peek("R1 seconds stop", 3'd1, 8'h80);
      peek("R1 weekday", 3'd4, 8'h01);

      // R9 stopped after reset: ticks change nothing
      idle(3, 1);
      idle(1, 0);
      peek("R9 stopped", 3'd1, 8'h80);

      // R10 low control bits
      cyc(1, 1, 3'd0, 8'h15, 0);
      peek("R10 readback", 3'd0, 8'h15);
      cyc(1, 1, 3'd0, 8'h00, 0);

      // R7 ignored write
      cyc(1, 1, 3'd2, 8'h33, 0);
      peek("R7 ignored", 3'd2, 8'h00);

      // R2 R8 full rollover
      set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      peek("R8 loaded", 3'd7, 8'h99);
      idle(1, 1);
      peek("R2 sec", 3'd1, 8'h00);
      peek("R2 hour", 3'd3, 8'h00);
      peek("R2 weekday", 3'd4, 8'h01);
      peek("R2 date", 3'd5, 8'h01);
      peek("R2 month", 3'd6, 8'h01);
      peek("R2 year", 3'd7, 8'h00);
      check_all("R2");

      // R3 February cases and a 30-day month
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
      idle(1, 1);
      peek("R3 leap 29", 3'd5, 8'h29);
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
      idle(1, 1);
      peek("R3 common date", 3'd5, 8'h01);
      peek("R3 common month", 3'd6, 8'h03);
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
      idle(1, 1);
      peek("R3 leap end", 3'd6, 8'h03);
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h10);
      idle(1, 1);
      peek("R3 april end", 3'd5, 8'h01);
      peek("R3 may", 3'd6, 8'h05);

      // R4 plain refresh
      set_time(8'h10, 8'h00, 8'h12, 8'h02, 8'h15, 8'h06, 8'h30);
      idle(1, 1);
      peek("R4 refresh", 3'd1, 8'h11);

      // R5 read freeze across ticks
      cyc(1, 1, 3'd0, 8'h40, 0);
      idle(5, 1);
      idle(1, 0);
      peek("R5 frozen", 3'd1, 8'h11);
      cyc(1, 1, 3'd0, 8'h00, 0);
      peek("R5 released no tick", 3'd1, 8'h11);
      idle(1, 1);
      peek("R5 caught up", 3'd1, 8'h17);

      // R6 freeze written in tick cycle
      cyc(1, 1, 3'd0, 8'h40, 1);
      idle(2, 1);
      peek("R6 refresh kept", 3'd1, 8'h18);
      cyc(1, 1, 3'd0, 8'h00, 0);

      // R10 low bits do not disturb timekeeping
      cyc(1, 1, 3'd0, 8'h3F, 1);
      idle(1, 0);
      peek("R10 counting", 3'd1, 8'h21);
      cyc(1, 1, 3'd0, 8'h00, 0);

      // R9 stop bit written under write freeze
      set_time(8'h85, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      idle(4, 1);
      idle(1, 0);
      peek("R9 halted", 3'd1, 8'h85);
      check_all("R9");

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         int op;
         bit t;
         op = int'($urandom_range(99));
         t = ($urandom_range(3) == 0);
         if (op < 55)
            idle(1, t);
         else if (op < 65)
            cyc(1, 1, 3'd0, {$urandom_range(1) == 1 ? 1'b1 : 1'b0,
                             $urandom_range(1) == 1 ? 1'b1 : 1'b0, 6'($urandom_range(63))}, t);
         else begin
            int a;
            a = int'($urandom_range(7, 1));
            cyc(1, 1, 3'(a), rnd_field(a), t);
         end
         if (n % 40 == 39) check_all("R4 random");
      end
      idle(1, 0);
      check_all("R8 final");
      finish_run();
   end

endmodule